// File: doc/BRIEF.md
# Radix-4 Carry-Save Montgomery Multiplier

This block computes the Montgomery product of two operands for an odd modulus: given A, B and M it returns A·B·R⁻¹ reduced modulo M, where R = 4^(N/2+1) and N is the modulus width. It is the inner multiply step of a modular exponentiation engine. The engine that drives it also supplies the small constant (−M⁻¹ mod 4), so the block does no precomputation of its own beyond the triples 3B and 3M.

Each clock of the main loop consumes one radix-4 digit of A, starting with the least significant digit. The running total is kept as two vectors, a sum and a carry, plus a one-bit carry into the next step. Digit multiples of B and quotient multiples of M are picked by a multiplexer from B, B shifted left, and a stored 3B (and likewise for M). Two stacked rows of 3:2 counters then fold the four terms into a new redundant pair, and the result is shifted right by two bits. The logic between registers in the loop therefore has a fixed depth whatever N is. After the loop, one carry-propagate addition and one conditional subtraction of M produce the binary result.

The interface is plain control. `start_i` launches an operation and is ignored while `busy_o` is high. `done_o` pulses for one cycle when `res_o` is valid, and `res_o` holds that value until the next operation completes. There is no back-pressure: a consumer must capture the result before it launches the following operation, or it reads the result while it is held.

Top module: `mont_r4_csa`

## Requirements
- R1: For an odd modulus M, operands A, B < 2M and `minv_i` = (−M⁻¹ mod 4), encoded as 3 when M mod 4 = 1 and as 1 when M mod 4 = 3, `res_o` equals A·B·4^−(N/2+1) mod M.
- R2: The returned value is always fully reduced, so `res_o` < M.
- R3: Count the clock edge that samples `start_i` as edge 1. `done_o` is high after edge N/2+5 and for that single cycle only.
- R4: From the accepting edge until the cycle in which `done_o` is high, `busy_o` is high. Any `start_i` seen while `busy_o` is high is ignored: it does not change the operands in use, the result or the latency.
- R5: Between two `done_o` pulses, `res_o` keeps the value it had at the earlier pulse.
- R6: A synchronous active-high `rst` leaves `busy_o` = 0, `done_o` = 0 and `res_o` = 0.
- R7: If either operand is zero, the result is zero.
- R8: Operands at the top of the allowed range (A = B = M−1 and A = B = 2M−1) give a correct result, and the loop's intermediate sums stay inside N+2 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch an operation; sampled only while idle |
| a_i | input | N+1 | Multiplier operand A, must be below 2M |
| b_i | input | N+1 | Multiplicand operand B, must be below 2M |
| m_i | input | N | Odd modulus M |
| minv_i | input | 2 | −M⁻¹ mod 4 (3 when M mod 4 = 1, 1 when M mod 4 = 3) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: `res_o` holds a new result |
| res_o | output | N | Montgomery product, fully reduced |

## Verification
On every loop cycle the assertions check that the quotient digit clears the two low bits of the redundant sum and that no sum or carry bit is lost above N+2 bits. They also check that the operand registers stay frozen while busy, that the result register moves only at completion, that `done_o` lasts a single cycle, and that the value about to be stored is below M. Only the bench scenarios can show that the product equals A·B·R⁻¹ mod M for random moduli and for the zero and range-edge operands. The same holds for the exact latency, the reset values, and a `start_i` pulse during a run having no effect on the result.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PREP = 3'd1,
    ST_RUN  = 3'd2,
    ST_CONV = 3'd3,
    ST_FIN  = 3'd4
  } mm_state_e;
endpackage

// File: rtl/mm_csa_row.sv
// One row of 3:2 counters; the carry vector is pre-shifted left and its
// free bit 0 takes an injected carry.
module mm_csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  input  logic         inj_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  assign c_o[0] = inj_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
    if (i < W - 1) begin : g_cy
      assign c_o[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
    end
  end
endmodule

// File: rtl/mm_mult_sel.sv
// Picks 0, X, 2X or 3X; 2X is wiring, 3X comes precomputed.
module mm_mult_sel #(
  parameter int IW = 16,
  parameter int OW = 20
) (
  input  logic [1:0]    sel_i,
  input  logic [IW-1:0] one_i,
  input  logic [IW+1:0] three_i,
  output logic [OW-1:0] mul_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    mul_o = '0;
      2'd1:    mul_o = OW'(one_i);
      2'd2:    mul_o = OW'({one_i, 1'b0});
      default: mul_o = OW'(three_i);
    endcase
  end
endmodule

// File: rtl/mm_step.sv
// One radix-4 iteration: (S + C + cin + d*B + q*M) / 4 in redundant form.
module mm_step #(
  parameter int N = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic [N+1:0]   s_i,
  input  logic [N+1:0]   c_i,
  input  logic           cin_i,
  input  logic [1:0]     dig_i,
  input  logic [1:0]     minv_i,
  input  logic [N:0]     b1_i,
  input  logic [N+2:0]   b3_i,
  input  logic [N-1:0]   m1_i,
  input  logic [N+1:0]   m3_i,
  output logic [N+1:0]   s_o,
  output logic [N+1:0]   c_o,
  output logic           cin_o
);
  localparam int AW = N + 2;
  localparam int XW = N + 5;

  logic [XW-1:0] bmul, mmul, s1, c1, s2, c2;
  logic [1:0]    low2, qdig;

  mm_mult_sel #(.IW(N+1), .OW(XW)) u_bsel (
    .sel_i(dig_i), .one_i(b1_i), .three_i(b3_i), .mul_o(bmul)
  );

  mm_csa_row #(.W(XW)) u_row1 (
    .x_i(XW'(s_i)), .y_i(XW'(c_i)), .z_i(bmul), .inj_i(cin_i),
    .s_o(s1), .c_o(c1)
  );

  // quotient digit from the two low bits of the partial redundant sum
  assign low2 = s1[1:0] + c1[1:0];
  assign qdig = low2 * minv_i;

  mm_mult_sel #(.IW(N), .OW(XW)) u_msel (
    .sel_i(qdig), .one_i(m1_i), .three_i(m3_i), .mul_o(mmul)
  );

  mm_csa_row #(.W(XW)) u_row2 (
    .x_i(s1), .y_i(c1), .z_i(mmul), .inj_i(1'b0),
    .s_o(s2), .c_o(c2)
  );

  // divide by four; a nonzero low pair always sums to four -> carry in
  assign s_o   = s2[AW+1:2];
  assign c_o   = c2[AW+1:2];
  assign cin_o = s2[1];

  AST_LOW_DIGIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    en_i |-> ((s2[1:0] + c2[1:0]) == 2'b00)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    en_i |-> ((s2[XW-1:AW+2] == '0) && (c2[XW-1:AW+2] == '0))); // R8
endmodule

// File: rtl/mm_final.sv
// Carry-propagated total minus M when it is not already below M.
module mm_final #(
  parameter int N = 64
) (
  input  logic [N+2:0] tot_i,
  input  logic [N-1:0] m_i,
  output logic [N+2:0] res_o
);
  logic [N+2:0] mext, diff;
  assign mext  = (N+3)'(m_i);
  assign diff  = tot_i - mext;
  assign res_o = (tot_i >= mext) ? diff : tot_i;
endmodule

// File: rtl/mont_r4_csa.sv
module mont_r4_csa
  import mm_pkg::*;
#(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [N:0]   a_i,
  input  logic [N:0]   b_i,
  input  logic [N-1:0] m_i,
  input  logic [1:0]   minv_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] res_o
);
  localparam int ITER = N / 2 + 1;
  localparam int AW   = N + 2;
  localparam int AD   = 2 * ITER;
  localparam int CW   = $clog2(ITER + 1);

  mm_state_e     state;
  logic [CW-1:0] cnt;
  logic [AD-1:0] a_sh;
  logic [N:0]    b_q;
  logic [N+2:0]  b3_q;
  logic [N-1:0]  m_q;
  logic [N+1:0]  m3_q;
  logic [1:0]    minv_q;
  logic [AW-1:0] s_q, c_q, s_nx, c_nx;
  logic          cin_q, cin_nx;
  logic [AW:0]   tot_q;
  logic [AW:0]   fin_res;
  logic [N-1:0]  res_q;
  logic          done_q;
  logic          run_en;

  assign run_en = (state == ST_RUN);

  mm_step #(.N(N)) u_step (
    .clk(clk), .rst(rst), .en_i(run_en),
    .s_i(s_q), .c_i(c_q), .cin_i(cin_q),
    .dig_i(a_sh[1:0]), .minv_i(minv_q),
    .b1_i(b_q), .b3_i(b3_q), .m1_i(m_q), .m3_i(m3_q),
    .s_o(s_nx), .c_o(c_nx), .cin_o(cin_nx)
  );

  mm_final #(.N(N)) u_final (
    .tot_i(tot_q), .m_i(m_q), .res_o(fin_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      a_sh   <= '0;
      b_q    <= '0;
      b3_q   <= '0;
      m_q    <= '0;
      m3_q   <= '0;
      minv_q <= '0;
      s_q    <= '0;
      c_q    <= '0;
      cin_q  <= 1'b0;
      tot_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            a_sh   <= AD'(a_i);
            b_q    <= b_i;
            m_q    <= m_i;
            minv_q <= minv_i;
            s_q    <= '0;
            c_q    <= '0;
            cin_q  <= 1'b0;
            state  <= ST_PREP;
          end
        end
        ST_PREP: begin
          b3_q  <= (N+3)'(b_q) + (N+3)'({b_q, 1'b0});
          m3_q  <= (N+2)'(m_q) + (N+2)'({m_q, 1'b0});
          cnt   <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          s_q   <= s_nx;
          c_q   <= c_nx;
          cin_q <= cin_nx;
          a_sh  <= a_sh >> 2;
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(ITER - 1)) state <= ST_CONV;
        end
        ST_CONV: begin
          tot_q <= (AW+1)'(s_q) + (AW+1)'(c_q) + (AW+1)'(cin_q);
          state <= ST_FIN;
        end
        ST_FIN: begin
          res_q  <= fin_res[N-1:0];
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state != ST_IDLE);
  assign done_o = done_q;
  assign res_o  = res_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R3
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_en |-> (cnt < CW'(ITER))); // R3
  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> ($stable(b_q) && $stable(m_q) && $stable(minv_q))); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_FIN) |=> $stable(res_q)); // R5
  AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |-> (fin_res < (AW+1)'(m_q))); // R2
endmodule

// File: tb/mont_r4_csa_bench.sv
`timescale 1ns/1ps
module mont_r4_csa_bench;
  localparam int N   = 64;
  localparam int LAT = N / 2 + 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [N:0]   a_i = '0;
  logic [N:0]   b_i = '0;
  logic [N-1:0] m_i = '0;
  logic [1:0]   minv_i = '0;
  logic         busy_o, done_o;
  logic [N-1:0] res_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  mont_r4_csa #(.N(N)) u_mont_r4_csa (
    .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .m_i(m_i), .minv_i(minv_i), .busy_o(busy_o), .done_o(done_o),
    .res_o(res_o)
  );

  function automatic logic [1:0] minv_of(input logic [N-1:0] m);
    return (m[1:0] == 2'b01) ? 2'd3 : 2'd1;
  endfunction

  // A*B*2^-(N+2) mod M by repeated halving modulo M
  function automatic logic [N-1:0] ref_mont(input logic [N:0] a,
                                            input logic [N:0] b,
                                            input logic [N-1:0] m);
    logic [2*N+3:0] aa, bb, mm, x;
    aa = {{(N+3){1'b0}}, a};
    bb = {{(N+3){1'b0}}, b};
    mm = {{(N+4){1'b0}}, m};
    x  = (aa * bb) % mm;
    for (int k = 0; k < N + 2; k++) begin
      if (x[0]) x = (x + mm) >> 1;
      else      x = x >> 1;
    end
    return x[N-1:0];
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [N:0] act, input logic [N:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // launch one operation and wait for its result
  task automatic run_op(input logic [N:0] a, input logic [N:0] b,
                        input logic [N-1:0] m, input string req,
                        output logic [N-1:0] got, output int lat);
    @(negedge clk);
    a_i = a; b_i = b; m_i = m; minv_i = minv_of(m); start_i = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    got = res_o;
  endtask

  task automatic op_check(input logic [N:0] a, input logic [N:0] b,
                          input logic [N-1:0] m, input string req);
    logic [N-1:0] got, exp;
    int lat;
    exp = ref_mont(a, b, m);
    run_op(a, b, m, req, got, lat);
    chk(lat == LAT, "R3 latency", N'(lat), N'(LAT));
    chk(got == exp, req, {1'b0, got}, {1'b0, exp});
    chk(got < m, "R2 reduced", {1'b0, got}, {1'b0, m});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 150000, LAT);
    finish_run();
  end

  initial begin
    logic [N-1:0] m, got, keep, exp;
    logic [N+1:0] big, twom;
    logic [N:0]   a, b;
    int lat;
    void'($urandom(32'd20250));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: reset state
    chk(busy_o == 1'b0, "R6 busy after reset", N'(busy_o), '0);
    chk(done_o == 1'b0, "R6 done after reset", N'(done_o), '0);
    chk(res_o == '0, "R6 result after reset", {1'b0, res_o}, '0);

    // R1: small directed case
    op_check(65'd5, 65'd7, 64'd11, "R1 small modulus");

    // R7: zero operands
    m = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
    op_check('0, (N+1)'(m - 64'd5), m, "R7 A zero");
    op_check((N+1)'(m - 64'd9), '0, m, "R7 B zero");

    // R8: upper edge of the operand range
    op_check((N+1)'(m - 64'd1), (N+1)'(m - 64'd1), m, "R8 A=B=M-1");
    m = '1;
    op_check({1'b0, m} + {1'b0, m} - 65'd1, {1'b0, m} + {1'b0, m} - 65'd1, m,
             "R8 A=B=2M-1 max modulus");
    op_check(65'd5, 65'd5, 64'd3, "R8 A=B=2M-1 modulus 3");

    // R1: random odd moduli, operands below M or below 2M
    for (int i = 0; i < 30; i++) begin
      m = {$urandom, $urandom} | 64'd1;
      if (i % 2 == 0) m[N-1] = 1'b1;
      if (m < 64'd3) m = 64'd3;
      twom = {2'b0, m} << 1;
      big = {$urandom, $urandom, $urandom};
      if (i % 3 == 0) begin
        a = (N+1)'(big % twom);
        big = {$urandom, $urandom, $urandom};
        b = (N+1)'(big % twom);
      end else begin
        a = (N+1)'(big % {2'b0, m});
        big = {$urandom, $urandom, $urandom};
        b = (N+1)'(big % {2'b0, m});
      end
      op_check(a, b, m, "R1 random");
    end

    // R5: result held between operations
    keep = res_o;
    repeat (10) @(negedge clk);
    chk(res_o == keep, "R5 result held", {1'b0, res_o}, {1'b0, keep});
    chk(done_o == 1'b0, "R3 done single pulse", N'(done_o), '0);

    // R4: start during a run is ignored
    m = 64'hF123_4567_89AB_CDEF;
    a = 65'h0_1111_2222_3333_4444;
    b = 65'h0_5555_6666_7777_8888;
    exp = ref_mont(a, b, m);
    @(negedge clk);
    a_i = a; b_i = b; m_i = m; minv_i = minv_of(m); start_i = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R4 busy after accept", N'(busy_o), 65'd1);
    a_i = 65'h1_0000_0000_0000_0003;
    b_i = 65'h0_0000_0000_0000_0009;
    m_i = 64'hFFFF_FFFF_FFFF_FFC5;
    minv_i = minv_of(m_i);
    while (!done_o && lat < 200) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (lat == 12) start_i = 1'b0;
      else if (lat == 6) start_i = 1'b1;
      if (!done_o && lat < LAT)
        chk(busy_o == 1'b1, "R4 busy during run", N'(busy_o), 65'd1);
    end
    start_i = 1'b0;
    chk(lat == LAT, "R4 latency with start while busy", N'(lat), N'(LAT));
    chk(res_o == exp, "R4 result with start while busy", {1'b0, res_o}, {1'b0, exp});
    chk(busy_o == 1'b0, "R4 idle at done", N'(busy_o), '0);

    // R3: back-to-back after done
    run_op(65'd3, 65'd4, 64'd13, "R3", got, lat);
    chk(lat == LAT, "R3 back-to-back latency", N'(lat), N'(LAT));
    exp = ref_mont(65'd3, 65'd4, 64'd13);
    chk(got == exp, "R1 back-to-back result", {1'b0, got}, {1'b0, exp});
    @(negedge clk);
    chk(done_o == 1'b0, "R3 done drops", N'(done_o), '0);

    finish_run();
  end
endmodule